// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Controller

This block is the device side of a three-wire serial memory link: chip select, serial clock, serial data in and serial data out. A host raises chip select, clocks in a start bit, a two-bit opcode and a word address, and the block then reads, programs, erases or changes its programming permission over an internal word array. Every pin is sampled by the system clock, and edges of chip select and serial clock are found by comparing successive samples. Data in is taken on each rising serial-clock edge.

Programming (single write, single erase, erase of every word, write of every word) is gated by an enable flag that is cleared by reset and set or cleared by two extended commands. Each accepted programming command starts a self-timed busy period of a fixed number of system-clock cycles. A host that drops chip select for long enough and raises it again during that period sees the busy state on the data output: 0 while busy, 1 once ready. The word width is 8 or 16 bits by parameter, and the address is one bit shorter in the 16-bit organisation.

Top module: `tw_eeprom_slave`

## Requirements
- R1: The data output is 0 whenever chip select is low and whenever chip select is high with neither a read transfer nor a status window active.
- R2: Bits are sampled on rising serial-clock edges. Zeros before the first 1 are skipped; that 1 is the start bit. Two opcode bits follow (10 read, 01 write, 11 erase, 00 extended), then the address MSB first. In the extended group the two top address bits select 11 enable, 00 disable, 10 erase every word, 01 write every word; the other address bits are ignored.
- R3: After the last address bit of a read, the output shows one 0 dummy bit, then each following rising serial-clock edge puts out the next bit of the addressed word, MSB first.
- R4: Reset clears the enable flag and leaves the array untouched. While the flag is clear, single write, single erase, erase-all and write-all leave the array unchanged; the enable command sets the flag and the disable command clears it.
- R5: A write takes one data word (8 or 16 bits, MSB first) after the address and stores it at that address.
- R6: An erase sets every bit of the addressed word to 1 and leaves other words unchanged.
- R7: Erase-all sets every word to all ones; write-all stores the one data word that follows the address into every word.
- R8: A busy period of PROG_CYCLES system-clock cycles starts when the last data bit of a write or write-all, or the last address bit of an erase or erase-all, is taken.
- R9: If chip select has been low for at least CS_LOW_MIN cycles and rises while busy, the output is 0 until the busy period ends, then 1 until chip select falls.
- R10: If chip select rises after the busy period has ended, or after a low time shorter than CS_LOW_MIN, no status is shown and the output stays 0.
- R11: A command clocked in while a busy period runs is ignored.
- R12: Dropping chip select before a command is complete abandons it and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data / ready-busy status to the host |

## Verification
The status window and the end of the self-timed busy period can land in the same cycle: the chip-select rise that opens the window may coincide with the cycle the busy counter reaches zero. The bench repeats a write while stepping the chip-select low time across that boundary in small steps. Long after each rise it judges the output. It must read 1 for every short low time, where the window opened while busy, and 0 for every long one. The outcome must switch exactly once, and both outcomes must occur.

// File: rtl/w3e_pkg.sv
// Shared encodings for the three-wire serial memory slave.
// Assumes: opcode values are fixed by the wire protocol.
package w3e_pkg;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        XT_DISABLE = 2'b00,
        XT_WR_ALL  = 2'b01,
        XT_ER_ALL  = 2'b10,
        XT_ENABLE  = 2'b11
    } ext_e;

    typedef enum logic [2:0] {
        F_OFF,
        F_START,
        F_OP,
        F_ADDR,
        F_DATA,
        F_READ,
        F_STATUS,
        F_DONE
    } fst_e;

endpackage

// File: rtl/w3e_sync.sv
// Input sampler: synchronises N asynchronous pins into the clock domain
// and gives a one-cycle rising-edge pulse for the lowest EDGE_N of them.
// Assumes: pins change slower than a few system-clock cycles.
module w3e_sync #(
    parameter int N      = 3,
    parameter int EDGE_N = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      raw_i,
    output logic [N-1:0]      lvl_o,
    output logic [EDGE_N-1:0] rise_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES:0] pipe;

        // shift the pin through the synchroniser plus one history stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[STAGES-1:0], raw_i[g]};
        end

        assign lvl_o[g] = pipe[STAGES-1];

        if (g < EDGE_N) begin : g_edge
            assign rise_o[g] = pipe[STAGES-1] & ~pipe[STAGES];
        end
    end

endmodule

// File: rtl/w3e_timer.sv
// Busy timer: models the self-timed programming cycle as a down-counter.
// Assumes: start_i only pulses while not busy.
module w3e_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] remain;

    // load on start, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)               remain <= '0;
        else if (start_i)         remain <= TW'(CYCLES);
        else if (remain != '0)    remain <= remain - 1'b1;
    end

    assign busy_o = (remain != '0);

endmodule

// File: rtl/w3e_store.sv
// Word array with an asynchronous read port, a single-word write port and
// a bulk fill that sweeps one word per cycle from address 0 upward.
// Assumes: the caller keeps the busy period longer than 2**AW cycles so a
// sweep always finishes inside it; contents are not cleared by reset.
module w3e_store #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    input  logic          one_i,
    input  logic          all_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          sweep_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] ptr;
    logic [DW-1:0] fill;
    logic          sweep;

    // bulk sweep control: start at word 0, stop after the last word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep <= 1'b0;
            ptr   <= '0;
            fill  <= '0;
        end else if (all_i) begin
            sweep <= 1'b1;
            ptr   <= '0;
            fill  <= wr_data_i;
        end else if (sweep) begin
            ptr <= ptr + 1'b1;
            if (ptr == '1) sweep <= 1'b0;
        end
    end

    // array update: bulk sweep or single word, never both
    always_ff @(posedge clk) begin
        if (sweep)      mem[ptr]       <= fill;
        else if (one_i) mem[wr_addr_i] <= wr_data_i;
    end

    assign rd_data_o = mem[rd_addr_i];
    assign sweep_o   = sweep;

endmodule

// File: rtl/w3e_decode.sv
// Frame decoder: walks start bit, opcode, address and data on serial-clock
// rising edges, drives read data out, issues programming requests and keeps
// the programming-enable flag and the chip-select low-time counter.
// Assumes: AW >= 2, DW >= 2, CS_LOW_MIN >= 1.
module w3e_decode
    import w3e_pkg::*;
#(
    parameter int AW         = 11,
    parameter int DW         = 8,
    parameter int CS_LOW_MIN = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_lvl,
    input  logic          cs_rise,
    input  logic          sk_rise,
    input  logic          di_lvl,
    input  logic          busy_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    output logic          go_o,
    output logic          one_o,
    output logic          all_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          status_o,
    output logic          en_o,
    output logic          dq_o
);

    localparam int CW = $clog2((AW > DW ? AW : DW) + 2);
    localparam int LW = $clog2(CS_LOW_MIN + 1);

    fst_e          st;
    op_e           op;
    logic [CW-1:0] cnt;
    logic [AW-1:0] addr_sh;
    logic [DW-1:0] data_sh;
    logic [LW-1:0] lowcnt;
    logic          en;
    logic          dq;
    logic [AW-1:0] addr_full;
    logic [DW-1:0] data_full;
    ext_e          xcode;

    assign addr_full = {addr_sh[AW-2:0], di_lvl};
    assign data_full = {data_sh[DW-2:0], di_lvl};
    assign xcode     = ext_e'(addr_full[AW-1:AW-2]);
    assign rd_addr_o = addr_full;

    // count chip-select low cycles, saturating at the minimum
    always_ff @(posedge clk) begin
        if (!rst_n)                          lowcnt <= '0;
        else if (cs_lvl)                     lowcnt <= '0;
        else if (lowcnt != LW'(CS_LOW_MIN))  lowcnt <= lowcnt + 1'b1;
    end

    // frame state machine, shift registers and enable flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= F_OFF;
            op      <= OP_EXT;
            cnt     <= '0;
            addr_sh <= '0;
            data_sh <= '0;
            en      <= 1'b0;
            dq      <= 1'b0;
            go_o    <= 1'b0;
            one_o   <= 1'b0;
            all_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            go_o  <= 1'b0;
            one_o <= 1'b0;
            all_o <= 1'b0;
            if (!cs_lvl) begin
                st <= F_OFF;
                dq <= 1'b0;
            end else begin
                unique case (st)
                    F_OFF: begin
                        if (cs_rise) begin
                            if (!busy_i)                          st <= F_START;
                            else if (lowcnt >= LW'(CS_LOW_MIN))   st <= F_STATUS;
                            else                                  st <= F_DONE;
                        end
                    end
                    F_START: begin
                        if (sk_rise && di_lvl) begin
                            st  <= F_OP;
                            cnt <= '0;
                        end
                    end
                    F_OP: begin
                        if (sk_rise) begin
                            op <= op_e'({op[0], di_lvl});
                            if (cnt == CW'(1)) begin
                                st  <= F_ADDR;
                                cnt <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    F_ADDR: begin
                        if (sk_rise) begin
                            addr_sh <= addr_full;
                            cnt     <= cnt + 1'b1;
                            if (cnt == CW'(AW - 1)) begin
                                cnt <= '0;
                                st  <= F_DONE;
                                unique case (op)
                                    OP_READ: begin
                                        st      <= F_READ;
                                        data_sh <= rd_data_i;
                                        dq      <= 1'b0;
                                    end
                                    OP_WRITE: st <= F_DATA;
                                    OP_ERASE: begin
                                        wr_addr_o <= addr_full;
                                        wr_data_o <= '1;
                                        one_o     <= en;
                                        go_o      <= en;
                                    end
                                    OP_EXT: begin
                                        unique case (xcode)
                                            XT_ENABLE:  en <= 1'b1;
                                            XT_DISABLE: en <= 1'b0;
                                            XT_WR_ALL:  st <= F_DATA;
                                            XT_ER_ALL: begin
                                                wr_data_o <= '1;
                                                all_o     <= en;
                                                go_o      <= en;
                                            end
                                        endcase
                                    end
                                endcase
                            end
                        end
                    end
                    F_DATA: begin
                        if (sk_rise) begin
                            data_sh <= data_full;
                            cnt     <= cnt + 1'b1;
                            if (cnt == CW'(DW - 1)) begin
                                st        <= F_DONE;
                                wr_addr_o <= addr_sh;
                                wr_data_o <= data_full;
                                one_o     <= en && (op == OP_WRITE);
                                all_o     <= en && (op == OP_EXT);
                                go_o      <= en;
                            end
                        end
                    end
                    F_READ: begin
                        if (sk_rise) begin
                            if (cnt == CW'(DW)) begin
                                dq <= 1'b0;
                                st <= F_DONE;
                            end else begin
                                dq      <= data_sh[DW-1];
                                data_sh <= {data_sh[DW-2:0], 1'b0};
                                cnt     <= cnt + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign status_o = (st == F_STATUS);
    assign en_o     = en;
    assign dq_o     = dq;

endmodule

// File: rtl/tw_eeprom_slave.sv
// Three-wire serial memory slave top: ties the input sampler, frame decoder,
// word array and busy timer together and selects the data-out source.
// Assumes: PROG_CYCLES exceeds the word count so bulk fills end while busy.
module tw_eeprom_slave #(
    parameter bit WORD16      = 1'b0,
    parameter int ADDR_X8_W   = 11,
    parameter int PROG_CYCLES = 5000,
    parameter int CS_LOW_MIN  = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o
);

    localparam int AW = WORD16 ? ADDR_X8_W - 1 : ADDR_X8_W;
    localparam int DW = WORD16 ? 16 : 8;

    logic [2:0]    pin_lvl;
    logic [1:0]    pin_rise;
    logic          cs_lvl;
    logic          busy;
    logic          prog_go;
    logic          prog_en;
    logic          status_on;
    logic          sweep;
    logic          wr_one;
    logic          wr_all;
    logic          dq;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] wr_data;

    w3e_sync #(.N(3), .EDGE_N(2), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({di_i, sk_i, cs_i}),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise)
    );

    assign cs_lvl = pin_lvl[0];

    w3e_decode #(.AW(AW), .DW(DW), .CS_LOW_MIN(CS_LOW_MIN)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_lvl    (cs_lvl),
        .cs_rise   (pin_rise[0]),
        .sk_rise   (pin_rise[1]),
        .di_lvl    (pin_lvl[2]),
        .busy_i    (busy),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .go_o      (prog_go),
        .one_o     (wr_one),
        .all_o     (wr_all),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .status_o  (status_on),
        .en_o      (prog_en),
        .dq_o      (dq)
    );

    w3e_store #(.AW(AW), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .one_i     (wr_one),
        .all_i     (wr_all),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .sweep_o   (sweep)
    );

    w3e_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_go),
        .busy_o  (busy)
    );

    // status window shows ready (1) or busy (0); otherwise the shift output
    assign do_o = status_on ? ~busy : dq;

endmodule

// File: rtl/w3e_chk.sv
// Property checker for the serial memory slave, bound into the top.
module w3e_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_lvl,
    input logic do_o,
    input logic go,
    input logic en,
    input logic busy,
    input logic status,
    input logic sweep
);

    AST_IDLE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_lvl && !$past(cs_lvl)) |-> !do_o);                          // R1

    AST_GO_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> en);                                                       // R4

    AST_GO_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);                                                     // R8

    AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);                                                    // R11

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status && $past(status) && $past(do_o)) |-> do_o);               // R9

    AST_SWEEP_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sweep |-> busy);                                                  // R7

endmodule

bind tw_eeprom_slave w3e_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_lvl (cs_lvl),
    .do_o   (do_o),
    .go     (prog_go),
    .en     (prog_en),
    .busy   (busy),
    .status (status_on),
    .sweep  (sweep)
);

// File: tb/test_tw_eeprom_slave.sv
module test_tw_eeprom_slave;

    localparam int AX   = 5;
    localparam int DW_T = 8;
    localparam int NW   = 1 << AX;
    localparam int PROG = 100;
    localparam int CSMN = 20;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic dout;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_rise = 0;
    logic [7:0] exp_mem [NW];

    tw_eeprom_slave #(
        .WORD16(1'b0), .ADDR_X8_W(AX), .PROG_CYCLES(PROG), .CS_LOW_MIN(CSMN)
    ) i_tw_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .do_o(dout)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        di = b; sk = 1'b1; last_rise = cyc;
        clks(HALF);
        sk = 1'b0;
        clks(HALF);
    endtask

    task automatic cs_on();
        cs = 1'b1;
        clks(HALF);
    endtask

    task automatic cs_off(input int n);
        cs = 1'b0; di = 1'b0;
        clks(n);
    endtask

    task automatic frame(input logic [1:0] op, input logic [AX-1:0] a);
        send_bit(1'b1);
        send_bit(op[1]); send_bit(op[0]);
        for (int i = AX - 1; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic send_data(input logic [7:0] d);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0;
        clks(5);
        rst_n = 1'b1;
        clks(3);
    endtask

    task automatic read_word(input int a, output logic [7:0] val, output logic dummy);
        cs_on();
        frame(2'b10, AX'(a));
        dummy = dout;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b0);
            val[i] = dout;
        end
        cs_off(10);
    endtask

    task automatic write_word(input int a, input logic [7:0] d, input int low);
        cs_on();
        frame(2'b01, AX'(a));
        send_data(d);
        cs_off(low);
    endtask

    task automatic erase_word(input int a, input int low);
        cs_on();
        frame(2'b11, AX'(a));
        cs_off(low);
    endtask

    task automatic ext_cmd(input logic [1:0] code, input logic [7:0] d, input logic with_data);
        cs_on();
        frame(2'b00, {code, {(AX-2){1'b0}}});
        if (with_data) send_data(d);
        cs_off(PROG + 20);
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        logic dm;
        int bad = 0;
        int first = -1;
        for (int a = 0; a < NW; a++) begin
            read_word(a, v, dm);
            if (v !== exp_mem[a] || dm !== 1'b0) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        if (first < 0) check(1'b1, req, 0, 0);
        else begin
            read_word(first, v, dm);
            check(1'b0, req, int'(v), int'(exp_mem[first]));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic dm;
        int t_ready;
        logic seen;
        logic saw_zero;
        logic saw_one;
        logic order_ok;

        do_reset();
        // R1: output idle after reset with chip select low
        check(dout === 1'b0, "R1 idle after reset", dout, 0);

        // R4: clear the array, then reset and try programming before enabling
        ext_cmd(2'b11, 8'h00, 1'b0);
        ext_cmd(2'b01, 8'h00, 1'b1);
        do_reset();
        write_word(3, 8'h5A, PROG + 20);
        erase_word(4, PROG + 20);
        read_word(3, v, dm);
        check(v === 8'h00, "R4 write ignored before enable", v, 0);
        read_word(4, v, dm);
        check(v === 8'h00, "R4 erase ignored before enable", v, 0);

        // R5 R2 R3: write a distinct value to every word, read all back
        ext_cmd(2'b11, 8'h00, 1'b0);
        for (int a = 0; a < NW; a++) begin
            exp_mem[a] = 8'((a * 37 + 11) & 8'hFF);
            write_word(a, exp_mem[a], PROG + 20);
        end
        check_all("R5 R3 write and read sweep");

        // R10: chip select raised after the busy period ended shows no status
        cs_on();
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            clks(1);
            if (dout !== 1'b0) seen = 1'b1;
        end
        check(seen === 1'b0, "R10 no status after cycle end", seen, 0);
        cs_off(10);

        // R6: single erase
        erase_word(7, PROG + 20);
        exp_mem[7] = 8'hFF;
        read_word(7, v, dm);
        check(v === 8'hFF, "R6 erased word", v, 8'hFF);
        read_word(6, v, dm);
        check(v === exp_mem[6], "R6 neighbour kept", v, exp_mem[6]);

        // R2: leading zeros before the start bit are skipped
        cs_on();
        send_bit(1'b0); send_bit(1'b0);
        frame(2'b10, AX'(9));
        dm = dout;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b0);
            v[i] = dout;
        end
        cs_off(10);
        check(v === exp_mem[9], "R2 leading zeros skipped", v, exp_mem[9]);
        check(dm === 1'b0, "R3 dummy bit is zero", dm, 0);

        // R12: abort a write mid-data
        cs_on();
        frame(2'b01, AX'(9));
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        cs_off(PROG + 20);
        read_word(9, v, dm);
        check(v === exp_mem[9], "R12 aborted write", v, exp_mem[9]);

        // R9 R8: status window during a write
        write_word(10, 8'h42, CSMN + 10);
        exp_mem[10] = 8'h42;
        cs = 1'b1;
        clks(HALF);
        check(dout === 1'b0, "R9 busy shows zero", dout, 0);
        t_ready = -1;
        for (int i = 0; i < 3 * PROG; i++) begin
            clks(1);
            if (t_ready < 0 && dout === 1'b1) t_ready = cyc;
        end
        check(t_ready >= 0, "R9 ready appears", t_ready, 1);
        check(t_ready - last_rise >= PROG + 2 && t_ready - last_rise <= PROG + 8,
              "R8 busy length", t_ready - last_rise, PROG + 4);
        check(dout === 1'b1, "R9 ready holds", dout, 1);
        cs_off(20);
        check(dout === 1'b0, "R1 idle after status", dout, 0);
        read_word(10, v, dm);
        check(v === 8'h42, "R5 written word", v, 8'h42);

        // R10: too short a low time gives no status even while busy
        write_word(11, 8'hC3, 3);
        exp_mem[11] = 8'hC3;
        cs = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 2 * PROG; i++) begin
            clks(1);
            if (dout !== 1'b0) seen = 1'b1;
        end
        check(seen === 1'b0, "R10 short low no status", seen, 0);
        cs_off(20);

        // R11: a write clocked in while busy is ignored
        write_word(12, 8'h11, CSMN + 5);
        exp_mem[12] = 8'h11;
        cs_on();
        frame(2'b01, AX'(13));
        send_data(8'h99);
        cs_off(PROG + 20);
        read_word(13, v, dm);
        check(v === exp_mem[13], "R11 write during busy ignored", v, exp_mem[13]);
        read_word(12, v, dm);
        check(v === 8'h11, "R5 word before busy", v, 8'h11);

        // R7: erase-all, then write-all
        ext_cmd(2'b10, 8'h00, 1'b0);
        for (int a = 0; a < NW; a++) exp_mem[a] = 8'hFF;
        check_all("R7 erase all");
        ext_cmd(2'b01, 8'h3C, 1'b1);
        for (int a = 0; a < NW; a++) exp_mem[a] = 8'h3C;
        check_all("R7 write all");

        // R4: disable, then programming has no effect
        ext_cmd(2'b00, 8'h00, 1'b0);
        write_word(5, 8'hE7, PROG + 20);
        erase_word(6, PROG + 20);
        ext_cmd(2'b10, 8'h00, 1'b0);
        check_all("R4 disabled after disable command");

        // R9 R10: sweep chip-select low time across the end of busy
        ext_cmd(2'b11, 8'h00, 1'b0);
        saw_zero = 1'b0;
        saw_one = 1'b0;
        order_ok = 1'b1;
        for (int k = 60; k <= 120; k += 5) begin
            write_word(20, 8'(k), k);
            cs = 1'b1;
            clks(150);
            if (dout === 1'b1) begin
                if (saw_zero) order_ok = 1'b0;
                saw_one = 1'b1;
            end else begin
                saw_zero = 1'b1;
            end
            cs_off(20);
        end
        check(order_ok, "R9 R10 single switch over low time", order_ok, 1);
        check(saw_one && saw_zero, "R9 R10 both outcomes", {saw_one, saw_zero}, 3);
        read_word(20, v, dm);
        check(v === 8'd120, "R5 last sweep write", v, 120);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule